// File: doc/BRIEF.md
# Mailbox Receive Queue

This block is the receive side of an inter-processor mailbox. Remote cores place 64-bit messages into a circular queue. Each message is tagged with the number of one of eight channels. The local processor reaches the queue through a small word-addressed register port. Three registers always show the oldest message: its channel tag, its low word and its high word. The processor retires that message by writing to a pop register.

Software reads both raw queue pointers and a separate full flag from one status word. When the two pointers are equal, the full flag tells a full queue from an empty one. A sticky pending bit records that messages are waiting. Writing one to that bit clears it. The interrupt line is the pending bit gated by a mask bit. A write of zero to the flush register drops every queued message at once.

Top module: `mbx_rx_fifo`

## Requirements
- R1: After reset both pointers are 0, the full flag is 0, the mask register (offset 0x1C, bits 4:0) reads 0x1F, the pending bit reads 0 and `irq` is low.
- R2: An accepted push stores channel, low word and high word at the write pointer. The write pointer then advances. Offset 0x00 (bits 2:0) shows the channel of the oldest entry, offset 0x04 its low word and offset 0x08 its high word.
- R3: A write to offset 0x0C with bit 0 set retires the oldest entry and advances the read pointer. A write with bit 0 clear changes nothing.
- R4: The status word at offset 0x14 carries the full flag in bit 0, the write pointer in bits 23:16 and the read pointer in bits 31:24. Pointers count modulo DEPTH. The full flag is set when a push makes the pointers equal.
- R5: A push that arrives while the queue is full is dropped. This holds also when a pop falls in the same cycle.
- R6: A pop while the queue is empty has no effect. A push in that same cycle is still accepted.
- R7: Offset 0x24 reads DEPTH-1.
- R8: The pending bit (offset 0x18, bit 0) becomes 1 one cycle after the queue is non-empty. A write with bit 0 set clears it. It sets again on the following cycle if entries remain.
- R9: `irq` equals the pending bit AND NOT mask bit 0. The mask field is a 5-bit read/write register.
- R10: A write of value 0 to offset 0x10 clears both pointers and the full flag. Any nonzero value written there has no effect.
- R11: A push and a pop in the same cycle on a queue that is neither empty nor full both take effect, and the occupancy stays the same.
- R12: `reg_rdata` shows the register selected by `reg_addr` one cycle after the address is presented. Unused offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 6 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| push_valid | input | 1 | Remote sender pushes a message this cycle |
| push_chan | input | 3 | Channel tag of the pushed message |
| push_lo | input | 32 | Low word of the pushed message |
| push_hi | input | 32 | High word of the pushed message |
| irq | output | 1 | Not-empty interrupt, masked |

## Verification
A remote push and a local pop can land on the same clock edge. The bench provokes this by raising `push_valid` in the same cycle as a pop-register write, with the queue in three states: partly filled, full and empty. The result is judged from the status word and the head registers. A partly filled queue must advance both pointers with the head moving on. A full queue must drop the push and clear the full flag. An empty queue must keep the push and ignore the pop.

// File: rtl/mbx_rx_pkg.sv
package mbx_rx_pkg;
  localparam int CH_W       = 3;
  localparam int WORD_W     = 32;
  localparam int ADDR_W     = 6;
  localparam int PFIELD_W   = 8;
  localparam int MASK_W     = 5;

  localparam logic [ADDR_W-1:0] OFF_CHAN  = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_LO    = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_HI    = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_POP   = 6'h0C;
  localparam logic [ADDR_W-1:0] OFF_FLUSH = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 6'h14;
  localparam logic [ADDR_W-1:0] OFF_PEND  = 6'h18;
  localparam logic [ADDR_W-1:0] OFF_MASK  = 6'h1C;
  localparam logic [ADDR_W-1:0] OFF_DEPTH = 6'h24;

  typedef struct packed {
    logic [CH_W-1:0]   chan;
    logic [WORD_W-1:0] hi;
    logic [WORD_W-1:0] lo;
  } msg_t;
endpackage

// File: rtl/mbx_rx_store.sv
module mbx_rx_store
  import mbx_rx_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  msg_t          wmsg_i,
  input  logic [AW-1:0] raddr_i,
  output msg_t          rmsg_o
);
  msg_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wmsg_i;
  end

  assign rmsg_o = mem[raddr_i];
endmodule

// File: rtl/mbx_rx_ptrs.sv
module mbx_rx_ptrs #(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          clr_i,
  output logic [AW-1:0] wr_o,
  output logic [AW-1:0] rd_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          push_ok_o
);
  logic [AW-1:0] wr_q, rd_q, wr_inc, rd_inc;
  logic          full_q, empty, push_ok, pop_ok;

  assign wr_inc  = wr_q + AW'(1);
  assign rd_inc  = rd_q + AW'(1);
  assign empty   = (wr_q == rd_q) && !full_q;
  assign push_ok = push_i && !full_q;
  assign pop_ok  = pop_i && !empty;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      wr_q   <= '0;
      rd_q   <= '0;
      full_q <= 1'b0;
    end else begin
      if (push_ok) wr_q <= wr_inc;
      if (pop_ok)  rd_q <= rd_inc;
      if (push_ok && !pop_ok && (wr_inc == rd_q)) full_q <= 1'b1;
      else if (pop_ok && !push_ok)                full_q <= 1'b0;
    end
  end

  assign wr_o      = wr_q;
  assign rd_o      = rd_q;
  assign full_o    = full_q;
  assign empty_o   = empty;
  assign push_ok_o = push_ok;

  a_r5_full_drops_push: assert property (@(posedge clk) disable iff (rst)
    (full_q && !clr_i) |=> (wr_q == $past(wr_q)));
  a_r6_empty_pop_idle: assert property (@(posedge clk) disable iff (rst)
    (empty && !clr_i) |=> (rd_q == $past(rd_q)));
  a_r4_full_ptrs_equal: assert property (@(posedge clk) disable iff (rst)
    full_q |-> (wr_q == rd_q));
  a_r3_pop_advances: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !empty && !clr_i) |=> (rd_q == AW'($past(rd_q) + AW'(1))));
  a_r10_flush_clears: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (wr_q == '0 && rd_q == '0 && !full_q));
endmodule

// File: rtl/mbx_rx_irq.sv
module mbx_rx_irq
  import mbx_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              pending_i,
  input  logic              ack_i,
  input  logic              mask_we_i,
  input  logic [MASK_W-1:0] mask_wdata_i,
  output logic              sts_o,
  output logic [MASK_W-1:0] mask_o,
  output logic              irq_o
);
  logic              sts_q;
  logic [MASK_W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q  <= 1'b0;
      mask_q <= '1;
    end else begin
      if (ack_i)          sts_q <= 1'b0;
      else if (pending_i) sts_q <= 1'b1;
      if (mask_we_i) mask_q <= mask_wdata_i;
    end
  end

  assign sts_o  = sts_q;
  assign mask_o = mask_q;
  assign irq_o  = sts_q & ~mask_q[0];

  a_r8_ack_clears: assert property (@(posedge clk) disable iff (rst)
    ack_i |=> !sts_q);
  a_r8_sets_when_waiting: assert property (@(posedge clk) disable iff (rst)
    (pending_i && !ack_i) |=> sts_q);
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    (sts_q && !ack_i) |=> sts_q);
endmodule

// File: rtl/mbx_rx_fifo.sv
module mbx_rx_fifo
  import mbx_rx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [5:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        push_valid,
  input  logic [2:0]  push_chan,
  input  logic [31:0] push_lo,
  input  logic [31:0] push_hi,
  output logic        irq
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [31:0] DEPTH_M1 = 32'(DEPTH - 1);

  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, empty, push_ok;
  logic          do_pop, do_flush, do_ack, mask_we;
  logic          pend_sts;
  logic [MASK_W-1:0] mask;
  msg_t          in_msg, head;
  logic [31:0]   stat_word, rd_mux;

  assign do_pop   = reg_wr && (reg_addr == OFF_POP) && reg_wdata[0];
  assign do_flush = reg_wr && (reg_addr == OFF_FLUSH) && (reg_wdata == 32'd0);
  assign do_ack   = reg_wr && (reg_addr == OFF_PEND) && reg_wdata[0];
  assign mask_we  = reg_wr && (reg_addr == OFF_MASK);

  assign in_msg = '{chan: push_chan, hi: push_hi, lo: push_lo};

  mbx_rx_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst(rst), .push_i(push_valid), .pop_i(do_pop), .clr_i(do_flush),
    .wr_o(wr_ptr), .rd_o(rd_ptr), .full_o(full), .empty_o(empty), .push_ok_o(push_ok)
  );

  mbx_rx_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .we_i(push_ok), .waddr_i(wr_ptr), .wmsg_i(in_msg),
    .raddr_i(rd_ptr), .rmsg_o(head)
  );

  mbx_rx_irq u_irq (
    .clk(clk), .rst(rst), .pending_i(!empty), .ack_i(do_ack),
    .mask_we_i(mask_we), .mask_wdata_i(reg_wdata[MASK_W-1:0]),
    .sts_o(pend_sts), .mask_o(mask), .irq_o(irq)
  );

  assign stat_word = {PFIELD_W'(rd_ptr), PFIELD_W'(wr_ptr), 15'd0, full};

  always_comb begin
    case (reg_addr)
      OFF_CHAN:  rd_mux = 32'(head.chan);
      OFF_LO:    rd_mux = head.lo;
      OFF_HI:    rd_mux = head.hi;
      OFF_STAT:  rd_mux = stat_word;
      OFF_PEND:  rd_mux = {31'd0, pend_sts};
      OFF_MASK:  rd_mux = 32'(mask);
      OFF_DEPTH: rd_mux = DEPTH_M1;
      default:   rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= 32'd0;
    else     reg_rdata <= rd_mux;
  end

  a_r12_depth_readback: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == OFF_DEPTH) |=> (reg_rdata == DEPTH_M1));
  a_r12_hole_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == 6'h20) |=> (reg_rdata == 32'd0));
endmodule

// File: tb/mbx_rx_fifo_test.sv
module mbx_rx_fifo_test;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        push_valid = 1'b0;
  logic [2:0]  push_chan = '0;
  logic [31:0] push_lo = '0, push_hi = '0;
  logic        irq;

  always #2 clk = ~clk;

  mbx_rx_fifo #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .push_valid(push_valid), .push_chan(push_chan),
    .push_lo(push_lo), .push_hi(push_hi), .irq(irq)
  );

  int n_chk = 0, n_bad = 0;

  // op: 0 push, 1 check head then pop, 2 check status word (low 32 bits of data)
  localparam logic [68:0] VEC [8] = '{
    {2'd0, 3'd1, 64'h11111111_A0000001},
    {2'd0, 3'd5, 64'h22222222_B0000002},
    {2'd2, 3'd0, 64'h00000000_00020000},
    {2'd1, 3'd1, 64'h11111111_A0000001},
    {2'd0, 3'd7, 64'h33333333_C0000003},
    {2'd1, 3'd5, 64'h22222222_B0000002},
    {2'd1, 3'd7, 64'h33333333_C0000003},
    {2'd2, 3'd0, 64'h00000000_03030000}
  };

  // reference queue from the requirements
  int mwp = 0, mrp = 0, mcnt = 0;
  logic [66:0] mq [DEPTH];

  function automatic logic [31:0] exp_stat();
    return {8'(mrp), 8'(mwp), 15'd0, (mcnt == DEPTH)};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic m_push(input logic [2:0] c, input logic [63:0] d);
    if (mcnt < DEPTH) begin
      mq[mwp] = {c, d};
      mwp = (mwp + 1) % DEPTH;
      mcnt++;
    end
  endtask

  task automatic m_pop();
    if (mcnt > 0) begin
      mrp = (mrp + 1) % DEPTH;
      mcnt--;
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic push(input logic [2:0] c, input logic [63:0] d);
    @(negedge clk);
    push_valid = 1'b1; push_chan = c; push_hi = d[63:32]; push_lo = d[31:0];
    @(posedge clk);
    @(negedge clk);
    push_valid = 1'b0;
    m_push(c, d);
  endtask

  task automatic push_pop(input logic [2:0] c, input logic [63:0] d);
    bit was_full, was_empty;
    @(negedge clk);
    push_valid = 1'b1; push_chan = c; push_hi = d[63:32]; push_lo = d[31:0];
    reg_addr = 6'h0C; reg_wdata = 32'd1; reg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    push_valid = 1'b0; reg_wr = 1'b0;
    was_full = (mcnt == DEPTH); was_empty = (mcnt == 0);
    if (!was_empty) m_pop();
    if (!was_full) m_push(c, d);
  endtask

  task automatic chk_head(input string tag);
    logic [31:0] v;
    rd(6'h00, v); chk({tag, " chan"}, 64'(v), 64'(mq[mrp][66:64]));
    rd(6'h04, v); chk({tag, " lo"}, 64'(v), 64'(mq[mrp][31:0]));
    rd(6'h08, v); chk({tag, " hi"}, 64'(v), 64'(mq[mrp][63:32]));
  endtask

  task automatic chk_stat(input string tag);
    logic [31:0] v;
    rd(6'h14, v); chk(tag, 64'(v), 64'(exp_stat()));
  endtask

  task automatic pop();
    wr(6'h0C, 32'd1);
    m_pop();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    rd(6'h14, v); chk("R1 status", 64'(v), 64'h0);
    rd(6'h1C, v); chk("R1 mask", 64'(v), 64'h1F);
    rd(6'h18, v); chk("R1 pending", 64'(v), 64'h0);
    chk("R1 irq", 64'(irq), 64'h0);
    // R7 depth, R12 hole
    rd(6'h24, v); chk("R7 depth", 64'(v), 64'(DEPTH - 1));
    rd(6'h20, v); chk("R12 unused offset", 64'(v), 64'h0);

    // vector table: R2 R3 R4
    for (int i = 0; i < 8; i++) begin
      case (VEC[i][68:67])
        2'd0: push(VEC[i][66:64], VEC[i][63:0]);
        2'd1: begin
          rd(6'h00, v); chk("R2 vec chan", 64'(v), 64'(VEC[i][66:64]));
          rd(6'h04, v); chk("R2 vec lo", 64'(v), 64'(VEC[i][31:0]));
          rd(6'h08, v); chk("R2 vec hi", 64'(v), 64'(VEC[i][63:32]));
          pop();
        end
        default: begin
          rd(6'h14, v); chk("R4 vec status", 64'(v), 64'(VEC[i][31:0]));
        end
      endcase
    end

    // R8: pending stayed set after the queue drained; ack clears it while empty
    rd(6'h18, v); chk("R8 sticky pending", 64'(v), 64'h1);
    wr(6'h18, 32'h1);
    rd(6'h18, v); chk("R8 ack while empty", 64'(v), 64'h0);

    // R6 pop on empty
    pop();
    chk_stat("R6 empty pop status");

    // R9 unmask, then push raises irq
    wr(6'h1C, 32'h1E);
    rd(6'h1C, v); chk("R9 mask readback", 64'(v), 64'h1E);
    chk("R9 irq idle", 64'(irq), 64'h0);
    push(3'd2, 64'h44444444_D0000004);
    @(negedge clk);
    chk("R9 irq raised", 64'(irq), 64'h1);
    // R8 ack with entry remaining: low for one cycle, then back
    wr(6'h18, 32'h1);
    chk("R8 cleared cycle", 64'(irq), 64'h0);
    @(negedge clk);
    chk("R8 reasserted", 64'(irq), 64'h1);
    // R9 mask hides irq but not pending
    wr(6'h1C, 32'h1F);
    chk("R9 masked irq", 64'(irq), 64'h0);
    rd(6'h18, v); chk("R9 pending under mask", 64'(v), 64'h1);

    // R3 trigger with bit0 clear is ignored
    wr(6'h0C, 32'h2);
    chk_stat("R3 bit0 clear status");
    chk_head("R3 head kept");

    // R11 simultaneous push and pop on partly filled queue
    push_pop(3'd3, 64'h55555555_E0000005);
    chk_stat("R11 status");
    chk_head("R11 head");

    // fill to full, with wrap: R4 R5
    while (mcnt < DEPTH) push(3'(mcnt), {32'h6600_0000 + 32'(mcnt), 32'hF000_0000 + 32'(mwp)});
    chk_stat("R4 full status");
    push(3'd6, 64'hDEADDEAD_DEADDEAD);
    chk_stat("R5 dropped push status");
    chk_head("R5 head after drop");
    // R5 push with pop while full: push dropped
    push_pop(3'd4, 64'hBADBAD00_BADBAD00);
    chk_stat("R5 full push_pop status");

    // R10 nonzero flush ignored, zero flush clears
    wr(6'h10, 32'h1);
    chk_stat("R10 nonzero flush");
    chk_head("R10 head kept");
    // drain three then flush
    for (int k = 0; k < 3; k++) begin
      chk_head("R2 drain head");
      pop();
    end
    chk_stat("R4 after drain");
    wr(6'h10, 32'h0);
    mwp = 0; mrp = 0; mcnt = 0;
    chk_stat("R10 flushed");

    // R6 push with pop on empty queue keeps the push
    push_pop(3'd1, 64'h77777777_77770007);
    chk_stat("R6 empty push_pop status");
    chk_head("R6 empty push_pop head");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule